// File: doc/BRIEF.md
# Partitioned Memory Region Access Controller

This block sits between the command decoder of a serial memory and its storage array. It checks every read and write request against a security setting held for each region of the array. The array is split into equal regions, and the upper address bits select the region. Each region runs in one of three modes:

- **Open:** every request passes.
- **Gated:** a read-permit bit and a write-permit bit decide each request.
- **Sealed:** only requests that arrive as authenticated packets carrying the current command counter pass.

The permit bits of gated regions load power-up values from parameters. After that, only an external authentication unit can change them. It does so with a one-cycle pulse that carries the expected counter value. Each accepted pulse or sealed access consumes one counter value, so a captured request cannot be replayed.

The decision is combinational in the request cycle. `acc_grant` enables the array. A denied read returns all ones instead of array data. Any denial or rejected update raises a sticky `viol` flag, which the host clears with `viol_clr`. The keyed MAC check and the non-volatile storage of the counter stay outside this block. The external unit presents its verdict on the `auth_*` ports and the `req_auth` flag.

Top module: `region_guard`

## Requirements
- R1: The region index is `req_addr[ADDR_W-1 -: 3]` (8 regions). The mode of region k is `REGION_MODE[2k+1:2k]`: 2'b00 open, 2'b01 gated, 2'b10 or 2'b11 sealed. With the default parameters, regions 0-3 are gated, 4-5 are open and 6-7 are sealed.
- R2: An open region grants every request, with or without `req_auth`.
- R3: In a gated region, a read is granted only when that region's read permit is set, and a write only when its write permit is set. The two permits are independent, and `req_auth` has no effect.
- R4: A denied read drives `rd_data` to all ones. A granted read drives `arr_rdata` onto `rd_data`. A denied write leaves `acc_grant` low, so the array is not written.
- R5: After reset, region k's read permit is `PWRUP_RD[k]` and its write permit is `PWRUP_WR[k]`. By default region 0 allows reads only and regions 1-3 allow nothing.
- R6: An `auth_ok` pulse with `auth_cnt == cmd_cnt` that targets a gated region loads `auth_rd_en`/`auth_wr_en` into that region's permits from the next cycle, and increments `cmd_cnt` by one.
- R7: An `auth_ok` pulse whose `auth_cnt` differs from `cmd_cnt` changes no permit, leaves `cmd_cnt` unchanged and sets `viol`.
- R8: A counter-matching `auth_ok` that targets an open or sealed region increments `cmd_cnt` and changes no permit.
- R9: A sealed region grants a request only when `req_auth` is set and `req_cnt == cmd_cnt`. Each granted sealed access increments `cmd_cnt`.
- R10: A sealed request that reuses an already consumed counter value is denied, and `cmd_cnt` does not move.
- R11: When a counter-matching `auth_ok` and a sealed request arrive in the same cycle, the update takes the counter. The request is denied and `cmd_cnt` rises by exactly one.
- R12: `viol` sets on any denied request or rejected `auth_ok` and holds until `viol_clr`. A new violation in the clearing cycle wins over the clear.
- R13: Reset sets `cmd_cnt` to 0 and clears `viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_auth | input | 1 | Request came as a MAC-verified packet |
| req_addr | input | ADDR_W | Array address |
| req_cnt | input | CNT_W | Counter value carried by the packet |
| arr_rdata | input | DATA_W | Data read from the array |
| acc_grant | output | 1 | Request allowed; array may act |
| acc_deny | output | 1 | Request refused |
| rd_data | output | DATA_W | Read data returned to the host |
| auth_ok | input | 1 | One-cycle permit-update pulse from the authentication unit |
| auth_region | input | 3 | Region targeted by the update |
| auth_rd_en | input | 1 | New read permit |
| auth_wr_en | input | 1 | New write permit |
| auth_cnt | input | CNT_W | Counter value the update was signed with |
| cmd_cnt | output | CNT_W | Current command counter |
| viol | output | 1 | Sticky access-violation flag |
| viol_clr | input | 1 | Clears `viol` |

## Verification
The embedded assertions check several rules on every cycle:

- a denied read always returns all ones;
- an open region never refuses;
- a sealed grant always carries `req_auth`;
- `cmd_cnt` moves by at most one, and only after an update pulse or an authenticated request;
- the permits hold still without `auth_ok`;
- `viol` stays set until cleared.

Only the bench's scenarios show the rest:

- the parameterised power-up permits;
- the independence of the read and write permits;
- rejection of a stale or replayed counter;
- the same-cycle collision between an update and a sealed access;
- set-over-clear on `viol`.

// File: rtl/region_guard.sv
module region_guard #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int NREG   = 8,
  parameter int CNT_W  = 8,
  parameter logic [2*NREG-1:0] REGION_MODE = 16'hA055,
  parameter logic [NREG-1:0]   PWRUP_RD    = 8'h01,
  parameter logic [NREG-1:0]   PWRUP_WR    = 8'h00
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_wr,
  input  logic                     req_auth,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [CNT_W-1:0]         req_cnt,
  input  logic [DATA_W-1:0]        arr_rdata,
  output logic                     acc_grant,
  output logic                     acc_deny,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     auth_ok,
  input  logic [$clog2(NREG)-1:0]  auth_region,
  input  logic                     auth_rd_en,
  input  logic                     auth_wr_en,
  input  logic [CNT_W-1:0]         auth_cnt,
  output logic [CNT_W-1:0]         cmd_cnt,
  output logic                     viol,
  input  logic                     viol_clr
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [1:0] M_OPEN  = 2'b00;
  localparam logic [1:0] M_GATED = 2'b01;

  logic [NREG-1:0]  rd_en, wr_en;
  logic [IDX_W-1:0] ridx;
  logic [1:0]       rmode, amode;
  logic             auth_match, upd, allow, seal_take;

  assign ridx       = req_addr[ADDR_W-1 -: IDX_W];
  assign rmode      = REGION_MODE[{ridx, 1'b0} +: 2];
  assign amode      = REGION_MODE[{auth_region, 1'b0} +: 2];
  assign auth_match = auth_ok && (auth_cnt == cmd_cnt);
  assign upd        = auth_match && (amode == M_GATED);

  always_comb begin
    case (rmode)
      M_OPEN:  allow = 1'b1;
      M_GATED: allow = req_wr ? wr_en[ridx] : rd_en[ridx];
      default: allow = req_auth && (req_cnt == cmd_cnt) && !auth_match;
    endcase
  end

  assign acc_grant = req_valid && allow;
  assign acc_deny  = req_valid && !allow;
  assign rd_data   = (acc_grant && !req_wr) ? arr_rdata : {DATA_W{1'b1}};
  assign seal_take = acc_grant && rmode[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en   <= PWRUP_RD;
      wr_en   <= PWRUP_WR;
      cmd_cnt <= '0;
      viol    <= 1'b0;
    end else begin
      if (upd) begin
        rd_en[auth_region] <= auth_rd_en;
        wr_en[auth_region] <= auth_wr_en;
      end
      if (auth_match || seal_take)
        cmd_cnt <= cmd_cnt + {{(CNT_W-1){1'b0}}, 1'b1};
      if (acc_deny || (auth_ok && !auth_match))
        viol <= 1'b1;
      else if (viol_clr)
        viol <= 1'b0;
    end
  end

  a_r4_deny_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_deny && !req_wr) |-> (rd_data == {DATA_W{1'b1}}));
  a_r2_open_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rmode == M_OPEN) |-> acc_grant);
  a_r9_sealed_needs_auth: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_grant && rmode[1]) |-> req_auth);
  a_r9_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cmd_cnt == $past(cmd_cnt)) || (cmd_cnt == $past(cmd_cnt) + 1'b1));
  a_r10_cnt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!auth_ok && !(req_valid && req_auth)) |=> $stable(cmd_cnt));
  a_r6_perm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !auth_ok |=> ($stable(rd_en) && $stable(wr_en)));
  a_r12_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !viol_clr) |=> viol);
endmodule

// File: tb/region_guard_tb.sv
module region_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 0, req_wr = 0, req_auth = 0;
  logic [11:0] req_addr = '0;
  logic [7:0] req_cnt = '0;
  logic [7:0] arr_rdata = 8'h5A;
  logic       acc_grant, acc_deny;
  logic [7:0] rd_data;
  logic       auth_ok = 0;
  logic [2:0] auth_region = '0;
  logic       auth_rd_en = 0, auth_wr_en = 0;
  logic [7:0] auth_cnt = '0;
  logic [7:0] cmd_cnt;
  logic       viol, viol_clr = 0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  region_guard u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_auth(req_auth), .req_addr(req_addr), .req_cnt(req_cnt),
    .arr_rdata(arr_rdata), .acc_grant(acc_grant), .acc_deny(acc_deny),
    .rd_data(rd_data), .auth_ok(auth_ok), .auth_region(auth_region),
    .auth_rd_en(auth_rd_en), .auth_wr_en(auth_wr_en), .auth_cnt(auth_cnt),
    .cmd_cnt(cmd_cnt), .viol(viol), .viol_clr(viol_clr));

  // {wr, auth, region[2:0], cnt[7:0], exp_grant}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 8'd0, 1'b1},  // R5 boot region readable
    {1'b1, 1'b0, 3'd0, 8'd0, 1'b0},  // R5 boot region not writable
    {1'b0, 1'b0, 3'd1, 8'd0, 1'b0},  // R5
    {1'b1, 1'b0, 3'd3, 8'd0, 1'b0},  // R5
    {1'b0, 1'b0, 3'd4, 8'd0, 1'b1},  // R2
    {1'b1, 1'b0, 3'd5, 8'd0, 1'b1},  // R2
    {1'b0, 1'b1, 3'd5, 8'd9, 1'b1},  // R2 auth flag irrelevant
    {1'b0, 1'b0, 3'd6, 8'd0, 1'b0},  // R9 legacy read to sealed
    {1'b1, 1'b0, 3'd7, 8'd0, 1'b0},  // R9 legacy write to sealed
    {1'b0, 1'b1, 3'd6, 8'd5, 1'b0},  // R9 wrong counter
    {1'b0, 1'b1, 3'd0, 8'd0, 1'b1},  // R3 auth flag ignored
    {1'b1, 1'b1, 3'd2, 8'd0, 1'b0}   // R3
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic req(input bit wr, input bit au, input int rg, input int cnt);
    @(negedge clk);
    req_valid = 1; req_wr = wr; req_auth = au;
    req_addr = 12'((rg << 9) | 3); req_cnt = 8'(cnt);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_wr = 0; req_auth = 0; auth_ok = 0; viol_clr = 0;
    #2;
  endtask

  task automatic auth(input int rg, input bit r, input bit w, input int cnt);
    @(negedge clk);
    auth_ok = 1; auth_region = 3'(rg); auth_rd_en = r; auth_wr_en = w; auth_cnt = 8'(cnt);
    #2;
  endtask

  task automatic gate_chk(input bit wr, input int rg, input bit g, input string tag);
    req(wr, 0, rg, 0);
    check(acc_grant == g, tag, acc_grant, g);
    check(rd_data == ((g && !wr) ? 8'h5A : 8'hFF), tag, rd_data, (g && !wr) ? 8'h5A : 8'hFF);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20 rst_n = 1;
    #1;
    check(cmd_cnt == 0, "R13 cnt", cmd_cnt, 0);
    check(viol == 0, "R13 viol", viol, 0);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      logic [7:0]  exp_rd;
      v = VEC[i];
      req(v[13], v[12], int'(v[11:9]), int'(v[8:1]));
      exp_rd = (v[0] && !v[13]) ? 8'h5A : 8'hFF;
      check(acc_grant == v[0] && acc_deny == !v[0], "R1 table grant", acc_grant, v[0]);
      check(rd_data == exp_rd, "R4 table rdata", rd_data, exp_rd);
    end
    idle();
    check(cmd_cnt == 0, "R9 no counter use", cmd_cnt, 0);
    check(viol == 1, "R12 viol set", viol, 1);
    @(negedge clk); viol_clr = 1; #2;
    idle();
    check(viol == 0, "R12 viol cleared", viol, 0);

    auth(1, 1, 1, 0); idle();
    check(cmd_cnt == 1, "R6 cnt", cmd_cnt, 1);
    gate_chk(0, 1, 1, "R6 rd");
    gate_chk(1, 1, 1, "R6 wr");

    auth(2, 0, 1, 1); idle();
    check(cmd_cnt == 2, "R3 cnt", cmd_cnt, 2);
    gate_chk(0, 2, 0, "R3 rd off");
    gate_chk(1, 2, 1, "R3 wr on");
    idle();
    @(negedge clk); viol_clr = 1; #2; idle();

    auth(3, 1, 1, 0); idle();
    check(cmd_cnt == 2, "R7 cnt", cmd_cnt, 2);
    check(viol == 1, "R7 viol", viol, 1);
    gate_chk(1, 3, 0, "R7 wr still off");
    gate_chk(0, 3, 0, "R7 rd still off");

    auth(4, 0, 0, 2); idle();
    check(cmd_cnt == 3, "R8 cnt", cmd_cnt, 3);
    gate_chk(0, 4, 1, "R8 open unchanged");

    req(0, 1, 6, 3);
    check(acc_grant == 1, "R9 sealed grant", acc_grant, 1);
    check(rd_data == 8'h5A, "R9 sealed rdata", rd_data, 8'h5A);
    idle();
    check(cmd_cnt == 4, "R9 cnt", cmd_cnt, 4);

    req(0, 1, 6, 3);
    check(acc_deny == 1, "R10 replay deny", acc_deny, 1);
    check(rd_data == 8'hFF, "R10 replay rdata", rd_data, 8'hFF);
    idle();
    check(cmd_cnt == 4, "R10 cnt", cmd_cnt, 4);

    @(negedge clk);
    auth_ok = 1; auth_region = 3'd0; auth_rd_en = 1; auth_wr_en = 1; auth_cnt = 8'd4;
    req_valid = 1; req_wr = 1; req_auth = 1; req_addr = 12'(7 << 9); req_cnt = 8'd4;
    #2;
    check(acc_deny == 1, "R11 collision deny", acc_deny, 1);
    idle();
    check(cmd_cnt == 5, "R11 cnt", cmd_cnt, 5);
    gate_chk(1, 0, 1, "R11 update applied");

    @(negedge clk); viol_clr = 1; #2; idle();
    check(viol == 0, "R12 cleared", viol, 0);
    @(negedge clk);
    viol_clr = 1; req_valid = 1; req_wr = 0; req_auth = 0; req_addr = 12'(6 << 9);
    #2; idle();
    check(viol == 1, "R12 set wins", viol, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule